// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Sequencer

This block sits between a synchronous host and an external asynchronous 32K x 8 static RAM. The host issues a one-cycle request carrying a read/write flag, a 15-bit word address and, for writes, a data byte. The block turns it into the chip-select, write-enable and output-enable sequence that the memory's datasheet minimums require. It drives the memory address, its own data-out bus with a separate drive enable, and samples the memory's data-in bus.

All memory timing is given as nanosecond parameters together with the clock period. The block converts each one to a cycle count, rounding up with a floor of one cycle. Writes always run with output enable held high. The block's own data drivers stay off until the memory has had a parameterised turnaround time to release the bus after its last read. Read data comes back with a one-cycle completion pulse. The busy flag covers each access until its cycle-time minimum has elapsed.

Top module: `sram_host_ctl`

## Requirements
- R1: While reset is high and in the first cycle after it, chip select, write enable and output enable are high (inactive), the data drive enable is low, and busy and done are low.
- R2: A request seen while busy is low is accepted at the next clock edge. From that edge, busy is high, chip select is low and the memory address equals the requested address. A request presented while busy is high has no effect on the address or the strobes. A request dropped before busy clears is never started.
- R3: A read holds chip select and output enable low and write enable high for exactly ACC cycles, where ACC is the larger of the address-access and output-enable-access counts (18 at defaults). On the last edge of that window the block captures the memory data onto the read-data port, raises chip select and output enable, and pulses done for one cycle.
- R4: A write holds write enable low for exactly PULSE cycles, where PULSE is the largest of the write-pulse, data-setup and address-to-end-of-write counts (13 at defaults). Chip select is low for at least AS cycles before write enable falls. The drive enable is high and the data-out bus carries the request data for the whole pulse.
- R5: The drive enable never rises sooner than TURN+1 cycles after output enable last rose, where TURN is the bus-release count (7 at defaults).
- R6: Busy stays high for exactly max(CYC, OP) cycles, where CYC is the read or write cycle-time count (18 at defaults). OP is ACC for a read and S+PULSE+WR for a write. S = max(AS, D+1), with D = max(0, TURN+1-G) and G the number of edges from the last output-enable rise to the write's acceptance edge.
- R7: Each phase count is the nanosecond value divided by the clock period, rounded up, and at least one. Zero-nanosecond address setup and write recovery therefore each take one cycle, and chip select is still low in the cycle after write enable rises.
- R8: A write ends by raising chip select, dropping the drive enable and pulsing done, all on the same edge, WR cycles after write enable rises.
- R9: Write enable is never low while output enable is low. The memory's read drive (chip select and output enable low, write enable high) and the block's drive enable are never active together.
- R10: Data written to any address is returned by a later read of that address, including addresses that use each upper address bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Access request, sampled while busy is low |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address of the request |
| req_wdata | input | 8 | Write data |
| rsp_rdata | output | 8 | Data captured by the last read |
| busy | output | 1 | Access in progress; requests are held off |
| done | output | 1 | One-cycle pulse when an access completes |
| mem_addr | output | 15 | Address to the memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 8 | Data returned by the memory |

## Verification
Two events can coincide. When a write is accepted right behind a read, the setup-phase counter and the bus-release wait run at the same time, and either one can decide when write enable falls. The bench provokes this by inserting 0 to 10 idle cycles between a read and the following write. For each spacing it compares the observed write-enable fall, busy length and done position against the closed-form S, OP and busy values. At the other end of each access, the read's done pulse lands on the same edge that clears busy, so the next request is accepted one cycle later. The bench holds requests across that boundary and checks the exact acceptance edge and address.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACC,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_RECOV,
    ST_HOLD
  } ctl_state_t;

  // Nanoseconds to whole clock cycles, rounded up, never below one.
  function automatic int ns_to_cyc(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
// Down-counter: loaded with N-1 on entry, reports last on the N-th cycle.
module sram_phase_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign last = (cnt == '0);
endmodule

// File: rtl/sram_turnaround_guard.sv
// Counts cycles since output enable rose; permits driving once the
// memory has had time to release the shared bus.
module sram_turnaround_guard #(
  parameter int HOLD_CYC = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic oe_n,
  output logic drive_ok
);
  localparam int G_W = $clog2(HOLD_CYC + 1) + 1;

  logic [G_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (!oe_n) begin
      cnt <= G_W'(HOLD_CYC);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign drive_ok = oe_n && (cnt == '0);
endmodule

// File: rtl/sram_host_ctl.sv
module sram_host_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W  = 15,
  parameter int DATA_W  = 8,
  parameter int CLK_NS  = 4,
  parameter int T_AS_NS = 0,
  parameter int T_WP_NS = 45,
  parameter int T_AW_NS = 50,
  parameter int T_DW_NS = 30,
  parameter int T_WR_NS = 0,
  parameter int T_WC_NS = 70,
  parameter int T_AA_NS = 70,
  parameter int T_OE_NS = 35,
  parameter int T_RC_NS = 70,
  parameter int T_HZ_NS = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int AS_CYC    = ns_to_cyc(T_AS_NS, CLK_NS);
  localparam int PULSE_CYC = imax(ns_to_cyc(T_WP_NS, CLK_NS),
                                  imax(ns_to_cyc(T_DW_NS, CLK_NS),
                                       ns_to_cyc(T_AW_NS, CLK_NS)));
  localparam int WR_CYC    = ns_to_cyc(T_WR_NS, CLK_NS);
  localparam int WC_CYC    = ns_to_cyc(T_WC_NS, CLK_NS);
  localparam int ACC_CYC   = imax(ns_to_cyc(T_AA_NS, CLK_NS),
                                  ns_to_cyc(T_OE_NS, CLK_NS));
  localparam int RC_CYC    = ns_to_cyc(T_RC_NS, CLK_NS);
  localparam int TURN_CYC  = ns_to_cyc(T_HZ_NS, CLK_NS);
  localparam int MAX_CYC   = imax(imax(imax(AS_CYC, PULSE_CYC), imax(WR_CYC, WC_CYC)),
                                  imax(ACC_CYC, RC_CYC));
  localparam int CNT_W     = $clog2(MAX_CYC + 1) + 1;

  ctl_state_t        state;
  logic              cs_n_q, we_n_q, oe_n_q, dq_oe_q, busy_q, done_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  logic             ph_load, ph_last, cyc_load, cyc_last, drive_ok;
  logic [CNT_W-1:0] ph_val, cyc_val;

  // Phase timer: setup, pulse, recovery and read-access windows.
  sram_phase_timer #(.CNT_W(CNT_W)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .load     (ph_load),
    .load_val (ph_val),
    .last     (ph_last)
  );

  // Cycle-time meter: enforces the read/write cycle minimum.
  sram_phase_timer #(.CNT_W(CNT_W)) u_cycle (
    .clk      (clk),
    .rst      (rst),
    .load     (cyc_load),
    .load_val (cyc_val),
    .last     (cyc_last)
  );

  sram_turnaround_guard #(.HOLD_CYC(TURN_CYC)) u_guard (
    .clk      (clk),
    .rst      (rst),
    .oe_n     (oe_n_q),
    .drive_ok (drive_ok)
  );

  always_comb begin
    ph_load  = 1'b0;
    ph_val   = '0;
    cyc_load = 1'b0;
    cyc_val  = '0;
    case (state)
      ST_IDLE: begin
        if (req) begin
          ph_load  = 1'b1;
          cyc_load = 1'b1;
          ph_val   = req_wr ? CNT_W'(AS_CYC - 1) : CNT_W'(ACC_CYC - 1);
          cyc_val  = req_wr ? CNT_W'(WC_CYC - 1) : CNT_W'(RC_CYC - 1);
        end
      end
      ST_WR_SETUP: begin
        if (ph_last && dq_oe_q) begin
          ph_load = 1'b1;
          ph_val  = CNT_W'(PULSE_CYC - 1);
        end
      end
      ST_WR_PULSE: begin
        if (ph_last) begin
          ph_load = 1'b1;
          ph_val  = CNT_W'(WR_CYC - 1);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cs_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req) begin
            busy_q <= 1'b1;
            cs_n_q <= 1'b0;
            addr_q <= req_addr;
            if (req_wr) begin
              wdata_q <= req_wdata;
              dq_oe_q <= drive_ok;
              state   <= ST_WR_SETUP;
            end else begin
              oe_n_q <= 1'b0;
              state  <= ST_RD_ACC;
            end
          end
        end
        ST_RD_ACC: begin
          if (ph_last) begin
            rdata_q <= mem_dq_in;
            done_q  <= 1'b1;
            cs_n_q  <= 1'b1;
            oe_n_q  <= 1'b1;
            if (cyc_last) begin
              busy_q <= 1'b0;
              state  <= ST_IDLE;
            end else begin
              state <= ST_HOLD;
            end
          end
        end
        ST_WR_SETUP: begin
          if (!dq_oe_q && drive_ok) dq_oe_q <= 1'b1;
          if (ph_last && dq_oe_q) begin
            we_n_q <= 1'b0;
            state  <= ST_WR_PULSE;
          end
        end
        ST_WR_PULSE: begin
          if (ph_last) begin
            we_n_q <= 1'b1;
            state  <= ST_WR_RECOV;
          end
        end
        ST_WR_RECOV: begin
          if (ph_last) begin
            cs_n_q  <= 1'b1;
            dq_oe_q <= 1'b0;
            done_q  <= 1'b1;
            if (cyc_last) begin
              busy_q <= 1'b0;
              state  <= ST_IDLE;
            end else begin
              state <= ST_HOLD;
            end
          end
        end
        ST_HOLD: begin
          if (cyc_last) begin
            busy_q <= 1'b0;
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rsp_rdata  = rdata_q;
  assign busy       = busy_q;
  assign done       = done_q;
  assign mem_addr   = addr_q;
  assign mem_cs_n   = cs_n_q;
  assign mem_we_n   = we_n_q;
  assign mem_oe_n   = oe_n_q;
  assign mem_dq_out = wdata_q;
  assign mem_dq_oe  = dq_oe_q;

endmodule

// File: rtl/sram_host_ctl_checker.sv
module sram_host_ctl_checker #(
  parameter int ADDR_W   = 15,
  parameter int TURN_CYC = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe
);
  localparam int GW = $clog2(TURN_CYC + 3) + 1;

  // Cycles since output enable was last low; saturates.
  logic [GW-1:0] gap;
  always_ff @(posedge clk) begin
    if (rst) begin
      gap <= '1;
    end else if (!mem_oe_n) begin
      gap <= '0;
    end else if (gap != '1) begin
      gap <= gap + 1'b1;
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && !busy && !done));

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !mem_cs_n |=> (mem_cs_n || $stable(mem_addr)));

  assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_pulse_driven_R4: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (mem_dq_oe && !mem_cs_n));

  assert_turnaround_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> (gap >= GW'(TURN_CYC + 1)));

  assert_done_in_busy_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));

  assert_no_oe_in_write_R9: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_oe_n);

  assert_no_contention_R9: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> (mem_oe_n && !mem_cs_n));

endmodule

bind sram_host_ctl sram_host_ctl_checker #(
  .ADDR_W   (ADDR_W),
  .TURN_CYC (TURN_CYC)
) u_checker (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .done      (done),
  .mem_addr  (mem_addr),
  .mem_cs_n  (mem_cs_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_host_ctl_test.sv
module sram_host_ctl_test;
  localparam int T     = 4;
  localparam int AA_NS = 70;

  function automatic int c_of(input int ns);
    int c;
    c = (ns + T - 1) / T;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int AS_C    = c_of(0);
  localparam int PULSE_C = mx(c_of(45), mx(c_of(30), c_of(50)));
  localparam int WR_C    = c_of(0);
  localparam int WC_C    = c_of(70);
  localparam int ACC_C   = mx(c_of(70), c_of(35));
  localparam int RC_C    = c_of(70);
  localparam int TURN_C  = c_of(25);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        req_wr = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [7:0]  rsp_rdata;
  logic        busy, done;
  logic [14:0] mem_addr;
  logic        mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in = 8'h00;

  always #2 clk = ~clk;

  sram_host_ctl uut (
    .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .busy(busy), .done(done),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  int nchk = 0;
  int nerr = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Memory model and expected contents (sparse).
  logic [7:0] sram [int];
  logic [7:0] expm [int];
  function automatic logic [7:0] pat0(input int a);
    return 8'((a * 5 + 3) ^ (a >> 8));
  endfunction
  function automatic logic [7:0] sram_rd(input int a);
    return sram.exists(a) ? sram[a] : pat0(a);
  endfunction
  function automatic logic [7:0] exp_rd(input int a);
    return expm.exists(a) ? expm[a] : pat0(a);
  endfunction

  int cyc_cnt = 0;
  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

  // Bus monitor and memory behaviour, evaluated between edges.
  logic        p_we_n = 1'b1, p_oe_n = 1'b1, p_dq_oe = 1'b0;
  logic [14:0] p_addr = '0;
  logic [7:0]  p_dq = '0;
  int wl_cnt = 0, setup_cnt = 0, gap = 1000, acc_cnt = 0;
  int oe_rise_cyc = -1000;

  always @(negedge clk) begin
    if (!rst) begin
      if (!mem_cs_n)
        chk(!(!mem_oe_n && mem_we_n && mem_dq_oe), "R9 bus contention", 1, 0);
      if (!mem_we_n) begin
        chk(mem_oe_n == 1'b1, "R9 oe high in write", int'(mem_oe_n), 1);
        wl_cnt++;
      end
      if (p_we_n && !mem_we_n) begin
        chk(setup_cnt >= AS_C, "R4 setup before pulse", setup_cnt, AS_C);
        chk(mem_dq_oe == 1'b1, "R4 data driven at pulse", int'(mem_dq_oe), 1);
      end
      if (!p_we_n && mem_we_n) begin
        chk(wl_cnt == PULSE_C, "R4 pulse width", wl_cnt, PULSE_C);
        chk(mem_cs_n == 1'b0, "R7 recovery cycle cs low", int'(mem_cs_n), 0);
        if (p_dq_oe) sram[int'(p_addr)] = p_dq;
        wl_cnt = 0;
      end
      if (!p_dq_oe && mem_dq_oe)
        chk(gap >= TURN_C + 1, "R5 turnaround", gap, TURN_C + 1);
      if (!p_oe_n && mem_oe_n) oe_rise_cyc = cyc_cnt;
      if (!mem_oe_n) gap = 0; else if (gap < 1000) gap++;
      if (mem_cs_n) setup_cnt = 0; else if (mem_we_n) setup_cnt++;
      if (!mem_cs_n && !mem_oe_n && mem_we_n) acc_cnt++; else acc_cnt = 0;
    end
    mem_dq_in = (acc_cnt > 0 && acc_cnt * T >= AA_NS) ? sram_rd(int'(mem_addr)) : 8'hxx;
    p_we_n  = mem_we_n;
    p_oe_n  = mem_oe_n;
    p_dq_oe = mem_dq_oe;
    p_addr  = mem_addr;
    p_dq    = mem_dq_out;
  end

  // One access; called at a negedge.
  task automatic do_op(input bit wr, input logic [14:0] a, input logic [7:0] d);
    int e0, g, dd, s, op, blen, n, done_at;
    logic [7:0] rd;
    while (busy) @(negedge clk);
    req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    e0 = cyc_cnt;
    req = 1'b0;
    chk(busy && !mem_cs_n, "R2 accepted next edge", int'(busy), 1);
    chk(mem_addr == a, "R2 address presented", int'(mem_addr), int'(a));
    if (wr) begin
      g  = e0 - oe_rise_cyc;
      dd = mx(0, TURN_C + 1 - g);
      s  = mx(AS_C, dd + 1);
      op = s + PULSE_C + WR_C;
      blen = mx(WC_C, op);
    end else begin
      op = ACC_C;
      blen = mx(RC_C, op);
    end
    n = 1; done_at = -1; rd = 8'h00;
    forever begin
      @(negedge clk);
      if (done) begin
        done_at = n;
        rd = rsp_rdata;
        if (wr) chk(mem_cs_n && !mem_dq_oe, "R8 write end with done", int'(mem_dq_oe), 0);
        else    chk(mem_cs_n && mem_oe_n, "R3 strobes release with done", int'(mem_oe_n), 1);
      end
      if (busy) n++; else break;
    end
    chk(n == blen, wr ? "R6 write busy length" : "R6 read busy length", n, blen);
    chk(done_at == op, wr ? "R8 write done position" : "R3 read done position", done_at, op);
    if (wr) expm[int'(a)] = d;
    else chk(rd == exp_rd(int'(a)), "R10 read data", int'(rd), int'(exp_rd(int'(a))));
  endtask

  function automatic logic [7:0] wpat(input int a);
    return 8'(a * 37 + 11);
  endfunction

  initial begin
    #(T * 150000);
    nerr++;
    nchk++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [14:0] ra, rb;
    repeat (4) @(negedge clk);
    chk(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && !busy && !done,
        "R1 reset state", int'(mem_dq_oe), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && !busy && !done,
        "R1 state after reset", int'(busy), 0);

    // Sweep of the low 256 words plus each upper address bit.
    for (int a = 0; a < 256; a++) do_op(1'b1, 15'(a), wpat(a));
    for (int b = 8; b < 15; b++) do_op(1'b1, 15'(1 << b), wpat(b * 101));
    do_op(1'b1, 15'h7fff, 8'h5a);
    for (int a = 0; a < 256; a++) do_op(1'b0, 15'(a), 8'h00);
    for (int b = 8; b < 15; b++) do_op(1'b0, 15'(1 << b), 8'h00);
    do_op(1'b0, 15'h7fff, 8'h00);

    // Read then write with 0..10 idle cycles: turnaround against setup.
    for (int k = 0; k <= 10; k++) begin
      do_op(1'b0, 15'(k), 8'h00);
      repeat (k) @(negedge clk);
      do_op(1'b1, 15'(300 + k), 8'(8'hc0 + k));
      do_op(1'b0, 15'(300 + k), 8'h00);
    end

    // Requests raised while busy are ignored and not queued.
    ra = 15'd17; rb = 15'd4000;
    while (busy) @(negedge clk);
    req = 1'b1; req_wr = 1'b0; req_addr = ra;
    @(negedge clk);
    req_wr = 1'b1; req_addr = rb; req_wdata = 8'hee;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(mem_addr == ra, "R2 addr unchanged while busy", int'(mem_addr), int'(ra));
      chk(mem_we_n && !mem_oe_n, "R2 op type unchanged while busy", int'(mem_we_n), 1);
    end
    req = 1'b0;
    while (busy) @(negedge clk);
    chk(rsp_rdata == exp_rd(int'(ra)), "R3 captured read data", int'(rsp_rdata),
        int'(exp_rd(int'(ra))));
    repeat (4) begin
      @(negedge clk);
      chk(mem_cs_n && !busy, "R2 dropped request not started", int'(mem_cs_n), 1);
    end
    do_op(1'b0, rb, 8'h00);

    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule